// File: doc/BRIEF.md
# Indirect Byte Store Controller with Guarded Writes

This block gives a processor access to a 1024-location byte store that is not mapped into its address space. Software reaches it through five small registers on a synchronous register port: two address registers, a data register, a control register and a key register. To read, software loads the address and sets the read-start bit in the control register. The addressed byte appears in the data register on the following clock.

Writes are guarded twice. The write-enable bit must be set, and the write-start bit must be set on the bus write that directly follows the two key bytes 55h and AAh, written in that order to the key register. An accepted write holds the store busy for a fixed number of cycles and then replaces the byte in one step, with no separate erase. It then raises a completion flag that only software can clear. A warm reset (external or watchdog) that arrives during a write cancels it, sets a sticky fault flag and zeroes the address and data registers. A power-on reset clears every register but leaves the stored bytes alone.

Register select codes: 0 address low (bits 7:0), 1 address high (bits 9:8 in bits 1:0), 2 data, 3 control, 4 key. Control bits: 0 read-start, 1 write-start, 2 write-enable, 3 fault, 4 done.

Top module: `nvbyte_ctrl`

## Requirements
- R1: Select 0 holds address bits 7:0. Select 1 holds address bits 9:8 in its bits 1:0, and its bits 7:2 always read as zero whatever value was written.
- R2: reg_rdata is registered. One clock edge after reg_sel is presented it shows the selected register as it stood before that edge. Select 2 shows the data byte, select 3 shows the control byte {3'b0, done, fault, enable, write-start, read-start}, and select 4 (key) and selects 5 to 7 always read zero.
- R3: Writing the control register with bit 0 set while no write is busy sets read-start. On the next edge the data register loads the byte at the current address and read-start clears on that same edge.
- R4: A control write with bit 1 or bit 0 clear never clears a start bit that is already set. Write-start is cleared only by write completion or a reset.
- R5: A write starts only when the control write carrying bit 1 comes directly after bus writes of 55h and then AAh to select 4, with no other bus write between them. Otherwise the write-start request is ignored and write-start stays 0.
- R6: The write-enable bit (control bit 2) is 0 after power-on reset. A write-start whose control value has bit 2 clear is ignored even after a correct key sequence.
- R7: An accepted write stores the data byte at the address exactly WR_CYCLES clock edges after the accepting edge. On that same edge write-start clears and done (bit 4, also driven on done_irq) sets.
- R8: While a write is busy, bus writes to the address and data registers and the read-start and write-start bits of the control register have no effect.
- R9: Done is cleared only by a control write with bit 4 at 0. A control write with bit 4 at 1 leaves it unchanged.
- R10: An ext_rst pulse zeroes the address and data registers and clears read-start, write-start and enable. If a write was busy it sets fault, cancels the write (the old byte stays) and done is not raised. An ext_rst with no write busy leaves fault unchanged.
- R11: Fault (bit 3) is sticky. It is cleared by a control write with bit 3 at 0 or by power-on reset.
- R12: rst clears the address, data and control registers, reg_rdata and done_irq.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ext_rst | input | 1 | Synchronous active-high warm (external or watchdog) reset |
| reg_sel | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data of the selected register |
| done_irq | output | 1 | Write-complete flag |

## Verification
The bench attacks the key sequence: it omits the key, breaks the sequence with an unrelated bus write, and sends the key with the enable bit clear. A design that armed too loosely would start a write and raise done. It fires read-start, write-start, new addresses and data while a write is busy, so a design without the busy guard would store at the wrong location or report a stale read. It times completion to the exact edge through done_irq, where an off-by-one timer shows up at once. It also aborts a write with a warm reset and then reads the location back: a design that committed anyway, forgot the fault flag, or kept the address would fail there.

// File: rtl/nvb_pkg.sv
package nvb_pkg;

  typedef enum logic [2:0] {
    SEL_ADDR_LO = 3'd0,
    SEL_ADDR_HI = 3'd1,
    SEL_DATA    = 3'd2,
    SEL_CTRL    = 3'd3,
    SEL_KEY     = 3'd4
  } nvb_sel_e;

  localparam int CB_RD    = 0;
  localparam int CB_WR    = 1;
  localparam int CB_ALLOW = 2;
  localparam int CB_FAULT = 3;
  localparam int CB_DONE  = 4;

  typedef enum logic [1:0] {
    UL_IDLE = 2'd0,
    UL_HALF = 2'd1,
    UL_OPEN = 2'd2
  } nvb_ul_e;

  typedef struct packed {
    logic done;
    logic fault;
    logic allow;
    logic wr_go;
    logic rd_go;
  } nvb_ctrl_t;

endpackage

// File: rtl/nvb_unlock.sv
module nvb_unlock
  import nvb_pkg::*;
#(
  parameter logic [7:0] KEY_A = 8'h55,
  parameter logic [7:0] KEY_B = 8'hAA
) (
  input  logic       clk,
  input  logic       clr,
  input  logic       bus_wr,
  input  logic       key_sel,
  input  logic [7:0] wdata,
  output logic       armed
);

  nvb_ul_e st, st_n;

  // Every bus write moves the tracker; only the exact key pair opens it.
  always_comb begin
    st_n = st;
    if (bus_wr) begin
      if (key_sel && wdata == KEY_A)
        st_n = UL_HALF;
      else if (key_sel && wdata == KEY_B && st == UL_HALF)
        st_n = UL_OPEN;
      else
        st_n = UL_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (clr) st <= UL_IDLE;
    else     st <= st_n;
  end

  assign armed = (st == UL_OPEN);

endmodule

// File: rtl/nvb_wtimer.sv
module nvb_wtimer #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic clr,
  input  logic start,
  output logic busy,
  output logic fin
);

  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (fin) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - CW'(1);
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= LOAD;
    end
  end

  assign fin = busy && (cnt == '0);

endmodule

// File: rtl/nvb_store.sv
module nvb_store #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Single port, read-before-write, no reset: maps onto a block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

endmodule

// File: rtl/nvbyte_ctrl.sv
module nvbyte_ctrl
  import nvb_pkg::*;
#(
  parameter int         ADDR_W    = 10,
  parameter int         WR_CYCLES = 16,
  parameter logic [7:0] KEY_A     = 8'h55,
  parameter logic [7:0] KEY_B     = 8'hAA
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ext_rst,
  input  logic [2:0] reg_sel,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       done_irq
);

  localparam int HI_W = ADDR_W - 8;

  logic [ADDR_W-1:0] addr;
  logic [7:0]        data;
  nvb_ctrl_t         ctrl;
  logic [7:0]        mem_q;
  logic [7:0]        rd_mux;
  logic              busy, fin, armed;
  logic              bus_ok, wr_lo, wr_hi, wr_dat, wr_ctl, wr_key;
  logic              start_wr, start_rd, warm_clr;

  assign bus_ok   = reg_wr && !ext_rst;
  assign wr_lo    = bus_ok && (reg_sel == SEL_ADDR_LO);
  assign wr_hi    = bus_ok && (reg_sel == SEL_ADDR_HI);
  assign wr_dat   = bus_ok && (reg_sel == SEL_DATA);
  assign wr_ctl   = bus_ok && (reg_sel == SEL_CTRL);
  assign wr_key   = bus_ok && (reg_sel == SEL_KEY);
  assign warm_clr = rst || ext_rst;

  assign start_wr = wr_ctl && !busy && armed &&
                    reg_wdata[CB_WR] && reg_wdata[CB_ALLOW];
  assign start_rd = wr_ctl && !busy && !start_wr && reg_wdata[CB_RD];

  nvb_unlock #(
    .KEY_A (KEY_A),
    .KEY_B (KEY_B)
  ) unlock_i (
    .clk     (clk),
    .clr     (warm_clr),
    .bus_wr  (bus_ok),
    .key_sel (wr_key),
    .wdata   (reg_wdata),
    .armed   (armed)
  );

  nvb_wtimer #(
    .CYCLES (WR_CYCLES)
  ) timer_i (
    .clk   (clk),
    .clr   (warm_clr),
    .start (start_wr),
    .busy  (busy),
    .fin   (fin)
  );

  nvb_store #(
    .AW (ADDR_W),
    .DW (8)
  ) store_i (
    .clk   (clk),
    .we    (fin && !warm_clr),
    .addr  (addr),
    .wdata (data),
    .rdata (mem_q)
  );

  // Register file
  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
      data <= '0;
      ctrl <= '0;
    end else if (ext_rst) begin
      addr       <= '0;
      data       <= '0;
      ctrl.rd_go <= 1'b0;
      ctrl.wr_go <= 1'b0;
      ctrl.allow <= 1'b0;
      if (busy) ctrl.fault <= 1'b1;
    end else begin
      if (!busy) begin
        if (wr_lo)  addr[7:0]        <= reg_wdata;
        if (wr_hi)  addr[ADDR_W-1:8] <= reg_wdata[HI_W-1:0];
        if (wr_dat) data             <= reg_wdata;
      end
      if (ctrl.rd_go) begin
        data       <= mem_q;
        ctrl.rd_go <= 1'b0;
      end
      if (wr_ctl) begin
        ctrl.allow <= reg_wdata[CB_ALLOW];
        if (!reg_wdata[CB_FAULT]) ctrl.fault <= 1'b0;
        if (!reg_wdata[CB_DONE])  ctrl.done  <= 1'b0;
      end
      if (start_rd) ctrl.rd_go <= 1'b1;
      if (start_wr) ctrl.wr_go <= 1'b1;
      if (fin) begin
        ctrl.wr_go <= 1'b0;
        ctrl.done  <= 1'b1;
      end
    end
  end

  // Read port
  always_comb begin
    case (reg_sel)
      SEL_ADDR_LO: rd_mux = addr[7:0];
      SEL_ADDR_HI: rd_mux = 8'(addr[ADDR_W-1:8]);
      SEL_DATA:    rd_mux = data;
      SEL_CTRL:    rd_mux = 8'(ctrl);
      default:     rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= 8'h00;
    else     reg_rdata <= rd_mux;
  end

  assign done_irq = ctrl.done;

endmodule

// File: rtl/nvb_ctrl_chk.sv
module nvb_ctrl_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              ext_rst,
  input logic [2:0]        reg_sel,
  input logic [7:0]        reg_rdata,
  input logic              done_irq,
  input logic              busy,
  input logic              fin,
  input logic              armed,
  input logic              rd_go,
  input logic              wr_go,
  input logic              allow,
  input logic              fault,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        data
);

  localparam int HI_W = ADDR_W - 8;

  assert_hi_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (reg_sel == 3'd1) |=> (reg_rdata[7:HI_W] == '0));

  assert_key_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_sel == 3'd4) |=> (reg_rdata == 8'h00));

  assert_read_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    rd_go |=> !rd_go);

  assert_wr_go_hw_clear_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_go) |-> ($past(fin) || $past(ext_rst) || $past(rst)));

  assert_start_needs_key_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(armed));

  assert_start_needs_enable_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> allow);

  assert_done_on_finish_R7: assert property (@(posedge clk) disable iff (rst)
    (fin && !ext_rst) |=> (done_irq && !wr_go));

  assert_busy_holds_regs_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && !ext_rst) |=> ($stable(addr) && $stable(data)));

  assert_fault_on_abort_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && ext_rst) |=> fault);

  assert_abort_zeroes_R10: assert property (@(posedge clk) disable iff (rst)
    ext_rst |=> (addr == '0 && data == 8'h00 && !busy));

endmodule

bind nvbyte_ctrl nvb_ctrl_chk #(
  .ADDR_W (ADDR_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .ext_rst   (ext_rst),
  .reg_sel   (reg_sel),
  .reg_rdata (reg_rdata),
  .done_irq  (done_irq),
  .busy      (busy),
  .fin       (fin),
  .armed     (armed),
  .rd_go     (ctrl.rd_go),
  .wr_go     (ctrl.wr_go),
  .allow     (ctrl.allow),
  .fault     (ctrl.fault),
  .addr      (addr),
  .data      (data)
);

// File: tb/nvbyte_ctrl_tb.sv
module nvbyte_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WRC        = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext_rst = 1'b0;
  logic [2:0] reg_sel = 3'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       done_irq;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvbyte_ctrl #(.WR_CYCLES(WRC)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .ext_rst   (ext_rst),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .done_irq  (done_irq)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_mem [int];
  logic [9:0] m_addr = '0;
  logic [7:0] m_data = '0;
  logic [7:0] m_rdata = '0;
  bit m_rd, m_wr, m_allow, m_fault, m_done, m_busy;
  int m_key = 0;
  int m_cyc = 0;
  int m_due = 0;

  always @(posedge clk) begin : model_b
    logic [7:0] v, rdv;
    bit busy0, open0, rd0, fin0;
    case (reg_sel)
      3'd0: m_rdata = m_addr[7:0];
      3'd1: m_rdata = {6'b0, m_addr[9:8]};
      3'd2: m_rdata = m_data;
      3'd3: m_rdata = {3'b0, m_done, m_fault, m_allow, m_wr, m_rd};
      default: m_rdata = 8'h00;
    endcase
    if (rst) begin
      m_rdata = 0; m_addr = 0; m_data = 0; m_key = 0;
      m_rd = 0; m_wr = 0; m_allow = 0; m_fault = 0; m_done = 0; m_busy = 0;
    end else if (ext_rst) begin
      if (m_busy) m_fault = 1;
      m_addr = 0; m_data = 0; m_key = 0;
      m_rd = 0; m_wr = 0; m_allow = 0; m_busy = 0;
    end else begin
      busy0 = m_busy; open0 = (m_key == 2); rd0 = m_rd; fin0 = 0;
      rdv = rd0 ? m_mem[int'(m_addr)] : 8'h00;
      if (m_busy && m_cyc == m_due) begin
        m_mem[int'(m_addr)] = m_data;
        m_busy = 0; m_wr = 0; fin0 = 1;
      end
      if (rd0) m_rd = 0;
      if (reg_wr) begin
        v = reg_wdata;
        case (reg_sel)
          3'd0: if (!busy0) m_addr[7:0] = v;
          3'd1: if (!busy0) m_addr[9:8] = v[1:0];
          3'd2: if (!busy0) m_data = v;
          3'd3: begin
            m_allow = v[2];
            if (!v[3]) m_fault = 0;
            if (!v[4]) m_done = 0;
            if (!busy0 && open0 && v[1] && v[2]) begin
              m_busy = 1; m_wr = 1; m_due = m_cyc + WRC;
            end else if (!busy0 && v[0]) m_rd = 1;
          end
          default: ;
        endcase
        if (reg_sel == 3'd4 && v == 8'h55) m_key = 1;
        else if (reg_sel == 3'd4 && v == 8'hAA && m_key == 1) m_key = 2;
        else m_key = 0;
      end
      if (rd0) m_data = rdv;
      if (fin0) m_done = 1;
    end
    m_cyc++;
  end

  always @(negedge clk) begin
    check(reg_rdata, m_rdata, "R2 per-cycle read port vs model");
    check({7'b0, done_irq}, {7'b0, m_done}, "R9 per-cycle done_irq vs model");
  end

  // ---------------- stimulus helpers ----------------
  task automatic bus_wr(input logic [2:0] s, input logic [7:0] v);
    reg_sel = s; reg_wdata = v; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] s, input logic [7:0] exp, input string tag);
    reg_sel = s; reg_wr = 1'b0;
    @(posedge clk); @(negedge clk);
    check(reg_rdata, exp, tag);
  endtask

  task automatic unlock_start();
    bus_wr(3'd4, 8'h55);
    bus_wr(3'd4, 8'hAA);
    bus_wr(3'd3, 8'h06);
  endtask

  task automatic wait_done();
    for (int i = 0; i < WRC + 4 && !done_irq; i++) @(negedge clk);
    check({7'b0, done_irq}, 8'h01, "R7 write completes");
  endtask

  task automatic pulse_ext();
    ext_rst = 1'b1;
    @(posedge clk); @(negedge clk);
    ext_rst = 1'b0;
  endtask

  task automatic full_write(input logic [9:0] a, input logic [7:0] d);
    bus_wr(3'd0, a[7:0]);
    bus_wr(3'd1, {6'b0, a[9:8]});
    bus_wr(3'd2, d);
    unlock_start();
    wait_done();
    bus_wr(3'd3, 8'h04);
  endtask

  task automatic read_at(input logic [9:0] a, input logic [7:0] exp, input string tag);
    bus_wr(3'd0, a[7:0]);
    bus_wr(3'd1, {6'b0, a[9:8]});
    bus_wr(3'd3, 8'h05);
    @(negedge clk);
    bus_rd(3'd2, exp, tag);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R7 watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    bus_rd(3'd3, 8'h00, "R12 control after reset");
    bus_rd(3'd0, 8'h00, "R12 address after reset");
    check({7'b0, done_irq}, 8'h00, "R12 done_irq after reset");

    // R1 address split
    bus_wr(3'd0, 8'h34);
    bus_wr(3'd1, 8'hFF);
    bus_rd(3'd1, 8'h03, "R1 high address upper bits read zero");
    bus_rd(3'd0, 8'h34, "R1 low address");
    bus_wr(3'd1, 8'hFE);
    bus_rd(3'd1, 8'h02, "R1 high address bits 9:8");
    bus_wr(3'd1, 8'h03);
    bus_wr(3'd2, 8'hA5);
    bus_rd(3'd2, 8'hA5, "R2 data register");

    // R5 no key
    bus_wr(3'd3, 8'h06);
    bus_rd(3'd3, 8'h04, "R5 start without key ignored");
    // R6 key but no enable
    bus_wr(3'd4, 8'h55);
    bus_wr(3'd4, 8'hAA);
    bus_wr(3'd3, 8'h02);
    bus_rd(3'd3, 8'h00, "R6 start without enable ignored");
    // R5 broken sequence
    bus_wr(3'd4, 8'h55);
    bus_wr(3'd2, 8'hA5);
    bus_wr(3'd4, 8'hAA);
    bus_wr(3'd3, 8'h06);
    bus_rd(3'd3, 8'h04, "R5 interrupted key sequence ignored");
    check({7'b0, done_irq}, 8'h00, "R5 no completion after ignored start");

    // R7 exact timing
    unlock_start();
    bus_rd(3'd3, 8'h06, "R5 proper key starts write");
    repeat (WRC - 2) @(negedge clk);
    check({7'b0, done_irq}, 8'h00, "R7 not done one edge early");
    @(negedge clk);
    check({7'b0, done_irq}, 8'h01, "R7 done on exact edge");
    bus_rd(3'd3, 8'h14, "R7 write-start cleared at completion");

    // R9 done clearing
    bus_wr(3'd3, 8'h14);
    check({7'b0, done_irq}, 8'h01, "R9 writing one keeps done");
    bus_wr(3'd3, 8'h04);
    check({7'b0, done_irq}, 8'h00, "R9 writing zero clears done");

    // R3 read timing
    bus_wr(3'd2, 8'h00);
    bus_wr(3'd3, 8'h05);
    bus_rd(3'd3, 8'h05, "R3 read-start visible for one cycle");
    bus_rd(3'd3, 8'h04, "R3 read-start self-cleared");
    bus_rd(3'd2, 8'hA5, "R3 read returns stored byte");

    // R8 / R4 ignore during busy
    bus_wr(3'd0, 8'hFF);
    bus_wr(3'd1, 8'h03);
    bus_wr(3'd2, 8'h5A);
    unlock_start();
    bus_wr(3'd0, 8'h00);
    bus_wr(3'd2, 8'h11);
    bus_wr(3'd3, 8'h05);
    bus_rd(3'd3, 8'h06, "R4 write-start not cleared by software, R8 read ignored");
    bus_rd(3'd0, 8'hFF, "R8 address write ignored while busy");
    bus_rd(3'd2, 8'h5A, "R8 data write ignored while busy");
    wait_done();
    bus_wr(3'd3, 8'h04);

    full_write(10'h000, 8'hC3);
    full_write(10'h100, 8'h11);
    read_at(10'h3FF, 8'h5A, "R7 byte stored at 3FFh");
    read_at(10'h000, 8'hC3, "R7 byte stored at 000h");
    read_at(10'h334, 8'hA5, "R7 first byte kept at 334h");

    // R10 abort
    bus_wr(3'd0, 8'h00);
    bus_wr(3'd1, 8'h01);
    bus_wr(3'd2, 8'h77);
    unlock_start();
    repeat (3) @(negedge clk);
    pulse_ext();
    bus_rd(3'd3, 8'h08, "R10 abort sets fault and clears control");
    bus_rd(3'd0, 8'h00, "R10 abort zeroes low address");
    bus_rd(3'd1, 8'h00, "R10 abort zeroes high address");
    bus_rd(3'd2, 8'h00, "R10 abort zeroes data");
    repeat (WRC + 2) @(negedge clk);
    check({7'b0, done_irq}, 8'h00, "R10 aborted write raises no done");
    bus_wr(3'd0, 8'h00);
    bus_wr(3'd1, 8'h01);
    bus_wr(3'd3, 8'h0D);
    @(negedge clk);
    bus_rd(3'd2, 8'h11, "R10 aborted write keeps old byte");
    bus_rd(3'd3, 8'h0C, "R11 fault sticky across control write");

    // R11 clear, R10 idle warm reset
    bus_wr(3'd3, 8'h04);
    bus_rd(3'd3, 8'h04, "R11 fault cleared by writing zero");
    pulse_ext();
    bus_rd(3'd3, 8'h00, "R10 idle warm reset clears enable, no fault");

    // R12 power reset clears fault
    unlock_start();
    pulse_ext();
    bus_rd(3'd3, 8'h08, "R10 second abort sets fault");
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    bus_rd(3'd3, 8'h00, "R12 reset clears fault");
    read_at(10'h100, 8'h11, "R12 stored byte survives reset");

    // R2 key and unused selects
    bus_wr(3'd4, 8'h55);
    bus_rd(3'd4, 8'h00, "R2 key register reads zero");
    bus_rd(3'd5, 8'h00, "R2 unused select 5 reads zero");
    bus_rd(3'd7, 8'h00, "R2 unused select 7 reads zero");

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule